// File: doc/BRIEF.md
# Outbound Window Translator

This block converts CPU-side physical addresses into PCIe bus addresses through a small set of programmable outbound windows. Each window covers a range of whole megabytes on the CPU side and carries a 64-bit PCIe target base. A request whose address falls inside a window is translated by replacing the window's CPU start with its target base. Requests that match no window are flagged as misses.

Software programs the windows through a write-only register port. Each window's megabyte start and end are 20-bit values. The low 12 bits of both sit together in one packed register. The top 8 bits of each have a register of their own. Translation is a comparator bank followed by a priority pick and one 64-bit add, and the result is registered once.

Top module: `owt_xlate`

## Requirements
- R1: After reset every window is disabled (start-MB high byte resets to 0xFF, all other fields to 0), so every request misses, and valid_o and hit_o are low.
- R2: The register map uses byte offsets with bits 1:0 zero, for N windows. The target low word of window n is at 8n and the target high word at 8n+4. The packed start/end register is at 8N+4n, with the start-MB bits 11:0 in bits 15:4 and the end-MB bits 11:0 in bits 31:20. The start-MB bits 19:12 are at 12N+8n, bits 7:0. The end-MB bits 19:12 are at 12N+8n+4, bits 7:0.
- R3: A CPU address hits window n when its MB index (address bits 39:20) lies between the window's start MB and end MB, with both ends included.
- R4: On a hit, pcie_addr_o equals the target base plus (cpu_addr_i minus start MB times 2^20).
- R5: When several windows hit, the lowest-numbered one is reported in win_o and used for the translation.
- R6: A window whose end MB is below its start MB never hits.
- R7: On a miss, hit_o is low and both win_o and pcie_addr_o are zero.
- R8: valid_o is high exactly one cycle after req_valid_i is high. hit_o is low whenever valid_o is low.
- R9: The translation add is taken modulo 2^64.
- R10: Writes to offsets outside the map, writes with bits 1:0 nonzero, and written bits outside the defined fields have no effect on translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| req_valid_i | input | 1 | Translation request valid |
| cpu_addr_i | input | 40 | CPU physical address |
| valid_o | output | 1 | Result valid, one cycle after request |
| hit_o | output | 1 | A window matched |
| win_o | output | 2 | Index of the matching window |
| pcie_addr_o | output | 64 | Translated PCIe address |

## Verification
Addresses are swept over each window's first and last MB and the MBs just outside them, with three page offsets each. This separates inclusive bounds from exclusive or off-by-one bounds, and it catches a lost offset field. Two windows overlap, and a later catch-all window covers every MB, so the sweep shows whether the lowest index wins. It also shows a disabled window staying silent until it is reprogrammed. One window has its start above its end and 20-bit bounds that use the high-byte registers. One window has a target near 2^64, which shows wraparound and splices of the high and low bytes. A final pass repeats the sweep after stray, misaligned and padded writes, to show that those writes changed nothing.

// File: rtl/owt_pkg.sv
package owt_pkg;
  localparam int MB_W     = 20;
  localparam int MB_SHIFT = 20;
  localparam int LO_W     = 12;
  localparam int HI_W     = MB_W - LO_W;
  localparam int CPU_AW   = MB_W + MB_SHIFT;
  localparam int PCIE_AW  = 64;
  localparam int DATA_W   = 32;
  localparam logic [HI_W-1:0] BASE_HI_RST = '1;

  typedef logic [MB_W-1:0]    mb_t;
  typedef logic [PCIE_AW-1:0] paddr_t;
endpackage

// File: rtl/owt_regfile.sv
module owt_regfile
  import owt_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int REG_AW  = 7
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [REG_AW-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [NUM_WIN-1:0][MB_W-1:0]  base_mb_o,
  output logic [NUM_WIN-1:0][MB_W-1:0]  lim_mb_o,
  output logic [NUM_WIN-1:0][PCIE_AW-1:0] tgt_o
);
  localparam int OFS_BL = 8 * NUM_WIN;
  localparam int OFS_HI = 12 * NUM_WIN;

  logic aligned;
  assign aligned = we_i && (addr_i[1:0] == 2'b00);

  for (genvar n = 0; n < NUM_WIN; n++) begin : g_win
    logic [DATA_W-1:0] tgt_lo_q, tgt_hi_q;
    logic [LO_W-1:0]   base_lo_q, lim_lo_q;
    logic [HI_W-1:0]   base_hi_q, lim_hi_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tgt_lo_q  <= '0;
        tgt_hi_q  <= '0;
        base_lo_q <= '0;
        lim_lo_q  <= '0;
        base_hi_q <= BASE_HI_RST;
        lim_hi_q  <= '0;
      end else if (aligned) begin
        if (int'(addr_i) == 8 * n)               tgt_lo_q <= wdata_i;
        if (int'(addr_i) == 8 * n + 4)           tgt_hi_q <= wdata_i;
        if (int'(addr_i) == OFS_BL + 4 * n) begin
          base_lo_q <= wdata_i[15:4];
          lim_lo_q  <= wdata_i[31:20];
        end
        if (int'(addr_i) == OFS_HI + 8 * n)      base_hi_q <= wdata_i[HI_W-1:0];
        if (int'(addr_i) == OFS_HI + 8 * n + 4)  lim_hi_q  <= wdata_i[HI_W-1:0];
      end
    end

    assign base_mb_o[n] = {base_hi_q, base_lo_q};
    assign lim_mb_o[n]  = {lim_hi_q, lim_lo_q};
    assign tgt_o[n]     = {tgt_hi_q, tgt_lo_q};
  end
endmodule

// File: rtl/owt_match.sv
module owt_match
  import owt_pkg::*;
#(
  parameter int NUM_WIN = 4
) (
  input  logic [NUM_WIN-1:0][MB_W-1:0] base_mb_i,
  input  logic [NUM_WIN-1:0][MB_W-1:0] lim_mb_i,
  input  logic [MB_W-1:0]              mb_i,
  output logic [NUM_WIN-1:0]           match_o
);
  for (genvar n = 0; n < NUM_WIN; n++) begin : g_cmp
    logic ge_base, le_lim;
    assign ge_base    = mb_i >= base_mb_i[n];
    assign le_lim     = mb_i <= lim_mb_i[n];
    // start above end implies one of the two compares fails
    assign match_o[n] = ge_base && le_lim;
  end
endmodule

// File: rtl/owt_select.sv
module owt_select
  import owt_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int WIN_W   = 2
) (
  input  logic [NUM_WIN-1:0]              match_i,
  input  logic [NUM_WIN-1:0][MB_W-1:0]    base_mb_i,
  input  logic [NUM_WIN-1:0][PCIE_AW-1:0] tgt_i,
  input  logic [CPU_AW-1:0]               cpu_addr_i,
  output logic                            hit_o,
  output logic [WIN_W-1:0]                win_o,
  output logic [PCIE_AW-1:0]              pcie_addr_o
);
  logic [MB_W-1:0]    rel_mb;
  logic [PCIE_AW-1:0] offset;

  always_comb begin
    win_o = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match_i[i]) win_o = WIN_W'(i);
    end
  end

  assign hit_o       = |match_i;
  assign rel_mb      = cpu_addr_i[CPU_AW-1:MB_SHIFT] - base_mb_i[win_o];
  assign offset      = PCIE_AW'({rel_mb, cpu_addr_i[MB_SHIFT-1:0]});
  assign pcie_addr_o = hit_o ? tgt_i[win_o] + offset : '0;
endmodule

// File: rtl/owt_xlate.sv
module owt_xlate
  import owt_pkg::*;
#(
  parameter int NUM_WIN = 4,
  localparam int REG_AW = $clog2(20 * NUM_WIN),
  localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [REG_AW-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  input  logic                req_valid_i,
  input  logic [CPU_AW-1:0]   cpu_addr_i,
  output logic                valid_o,
  output logic                hit_o,
  output logic [WIN_W-1:0]    win_o,
  output logic [PCIE_AW-1:0]  pcie_addr_o
);
  logic [NUM_WIN-1:0][MB_W-1:0]    base_mb, lim_mb;
  logic [NUM_WIN-1:0][PCIE_AW-1:0] tgt;
  logic [NUM_WIN-1:0]              match_w;
  logic                            hit_d;
  logic [WIN_W-1:0]                win_d;
  logic [PCIE_AW-1:0]              pa_d;

  owt_regfile #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .base_mb_o(base_mb),
    .lim_mb_o (lim_mb),
    .tgt_o    (tgt)
  );

  owt_match #(.NUM_WIN(NUM_WIN)) u_match (
    .base_mb_i(base_mb),
    .lim_mb_i (lim_mb),
    .mb_i     (cpu_addr_i[CPU_AW-1:MB_SHIFT]),
    .match_o  (match_w)
  );

  owt_select #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_sel (
    .match_i    (match_w),
    .base_mb_i  (base_mb),
    .tgt_i      (tgt),
    .cpu_addr_i (cpu_addr_i),
    .hit_o      (hit_d),
    .win_o      (win_d),
    .pcie_addr_o(pa_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      hit_o       <= 1'b0;
      win_o       <= '0;
      pcie_addr_o <= '0;
    end else begin
      valid_o     <= req_valid_i;
      hit_o       <= req_valid_i && hit_d;
      win_o       <= req_valid_i ? win_d : '0;
      pcie_addr_o <= req_valid_i ? pa_d : '0;
    end
  end
endmodule

// File: rtl/owt_xlate_chk.sv
module owt_xlate_chk #(
  parameter int NUM_WIN = 4,
  parameter int WIN_W   = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               valid_o,
  input logic               hit_o,
  input logic [WIN_W-1:0]   win_o,
  input logic [63:0]        pcie_addr_o,
  input logic [NUM_WIN-1:0] match_w
);
  a_r8_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> valid_o);
  a_r8_idle_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !valid_o);
  a_r8_no_hit_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !hit_o);
  a_r7_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !hit_o) |-> (pcie_addr_o == 64'd0 && win_o == '0));
  a_r3_hit_tracks_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (hit_o == (|$past(match_w))));
  a_r5_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (!hit_o || ($past(match_w)[win_o] &&
      (($past(match_w) & ((NUM_WIN'(1) << win_o) - NUM_WIN'(1))) == '0))));
endmodule

bind owt_xlate owt_xlate_chk #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .valid_o    (valid_o),
  .hit_o      (hit_o),
  .win_o      (win_o),
  .pcie_addr_o(pcie_addr_o),
  .match_w    (match_w)
);

// File: tb/owt_xlate_tb.sv
module owt_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [6:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic        req = 1'b0;
  logic [39:0] caddr = '0;
  logic        valid_o, hit_o;
  logic [1:0]  win_o;
  logic [63:0] pa_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [19:0] m_base [4];
  logic [19:0] m_lim  [4];
  logic [63:0] m_tgt  [4];

  always #4 clk = ~clk;

  owt_xlate u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(waddr),
    .reg_wdata_i(wdata), .req_valid_i(req), .cpu_addr_i(caddr),
    .valid_o(valid_o), .hit_o(hit_o), .win_o(win_o), .pcie_addr_o(pa_o)
  );

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; waddr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  // R2 map: tgt 8n/8n+4, packed 0x20+4n, start hi 0x30+8n, end hi 0x34+8n
  task automatic prog(input int n, input logic [19:0] b, input logic [19:0] l,
                      input logic [63:0] t);
    wr(7'(8 * n), t[31:0]);
    wr(7'(8 * n + 4), t[63:32]);
    wr(7'(32 + 4 * n), {l[11:0], 4'h0, b[11:0], 4'h0});
    wr(7'(48 + 8 * n), {24'h0, b[19:12]});
    wr(7'(52 + 8 * n), {24'h0, l[19:12]});
    m_base[n] = b; m_lim[n] = l; m_tgt[n] = t;
  endtask

  task automatic model(input logic [39:0] a, output bit h, output int w,
                       output logic [63:0] p);
    logic [19:0] mb;
    mb = a[39:20]; h = 0; w = 0; p = '0;
    for (int i = 3; i >= 0; i--)
      if (m_lim[i] >= m_base[i] && mb >= m_base[i] && mb <= m_lim[i]) begin
        h = 1; w = i;
      end
    if (h) p = m_tgt[w] + (64'(mb) - 64'(m_base[w])) * 64'h10_0000 + 64'(a[19:0]);
  endtask

  task automatic xl(input logic [39:0] a, input string rq);
    bit eh; int ew; logic [63:0] ep;
    @(negedge clk); req = 1'b1; caddr = a;
    @(negedge clk); req = 1'b0;
    model(a, eh, ew, ep);
    n_run++;
    if (valid_o !== 1'b1 || hit_o !== eh || win_o !== 2'(ew) || pa_o !== ep) begin
      n_fail++;
      $display("FAIL %s addr=%h got v=%b h=%b w=%0d pa=%h exp v=1 h=%b w=%0d pa=%h",
               rq, a, valid_o, hit_o, win_o, pa_o, eh, ew, ep);
    end
  endtask

  task automatic sweep(input string rq);
    logic [19:0] pts [6];
    logic [19:0] offs [3];
    offs[0] = 20'h0; offs[1] = 20'hFFFFF; offs[2] = 20'h12345;
    for (int w = 0; w < 4; w++) begin
      pts[0] = m_base[w] - 20'd1; pts[1] = m_base[w]; pts[2] = m_base[w] + 20'd1;
      pts[3] = m_lim[w] - 20'd1;  pts[4] = m_lim[w];  pts[5] = m_lim[w] + 20'd1;
      for (int p = 0; p < 6; p++)
        for (int o = 0; o < 3; o++) xl({pts[p], offs[o]}, rq);
    end
    xl(40'h0, rq);
    xl(40'hFF_FFFF_FFFF, rq);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_base[i] = 20'hFF000; m_lim[i] = '0; m_tgt[i] = '0;
    end
    repeat (3) @(negedge clk);
    n_run++;
    if (valid_o !== 1'b0 || hit_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset outputs v=%b h=%b exp 0 0", valid_o, hit_o);
    end
    rst_n = 1'b1;
    // R1: reset state, all windows disabled
    sweep("R1 R7");

    prog(0, 20'h00100, 20'h001FF, 64'h0000_0040_0000_0000);
    prog(1, 20'h001F0, 20'h00300, 64'h0000_0000_1000_0000);
    prog(2, 20'hAB123, 20'hAB124, 64'hFFFF_FFFF_FFF0_0000);
    prog(3, 20'h50000, 20'h4FFFF, 64'h1234_0000_0000_0000);
    // R2 R3 R4 R5 R6 R7 R9
    sweep("R2 R3 R4 R5 R6 R7 R9");

    // R8: idle cycle after a request drops valid_o
    @(negedge clk);
    n_run++;
    if (valid_o !== 1'b0 || hit_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R8 idle v=%b h=%b exp 0 0", valid_o, hit_o);
    end

    // R10: stray, misaligned and padded writes
    wr(7'h50, 32'hFFFF_FFFF);
    wr(7'h7C, 32'hFFFF_FFFF);
    wr(7'h01, 32'hDEAD_BEEF);
    wr(7'h22, 32'h0000_0000);
    wr(7'h24, {m_lim[1][11:0], 4'hF, m_base[1][11:0], 4'hF});
    wr(7'h38, {24'hFFFFFF, m_base[1][19:12]});
    sweep("R10");

    // R5 R6: catch-all window 3 behind the others
    prog(3, 20'h00000, 20'hFFFFF, 64'h1234_0000_0000_0000);
    sweep("R5 R6");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule